// File: doc/BRIEF.md
# Disk Identification Probe Sequencer

This block probes one position (primary or secondary unit) on a parallel disk-drive bus and fetches the 512-byte identification block that a compliant drive returns. It works the eight-register task-file port on the host side. It reads the status register once before touching the bus, to detect a floating bus. It then selects the unit, zeroes the count and address registers, issues the identify command and polls status. When busy drops, it reads the two signature bytes. It then waits for data-ready or error and reads 256 words, each streamed out with its index.

Each probe ends with a one-cycle done pulse and a 3-bit result code. The code says the unit is absent, is a disk with data, is a packet-style or serial device, has reported an error, or did not answer in time. The sector capacities for 28-bit and 48-bit addressing, and the 48-bit support flag, are captured from fixed words of the identification block as they stream past. The poll timeout is a cycle count given at an input.

Top module: `ata_ident_probe`

## Requirements
- R1: After start, the first bus access is a read of offset 7 (status). If its low byte is 0xFF, the probe ends with result 1 (floating bus), and no register write happens during that probe.
- R2: Otherwise the block writes, in this order: offset 6 with 0xA0 (primary) or 0xB0 (secondary, when `unit_sel_i`=1), then 0x00 to offsets 2, 3, 4 and 5, then 0xEC to offset 7.
- R3: The status read right after the command is checked. A value of 0x00 ends the probe with result 2 (no device).
- R4: Status is then re-read while bit 7 (busy) is 1. Every other status bit is ignored while busy is set, including bit 0 (error).
- R5: Once busy is clear, offsets 4 and 5 are read and their bytes appear on `sig_mid_o` and `sig_hi_o`. If either byte is non-zero, the probe ends with result 3 (non-disk device). This takes priority over any error flag.
- R6: Status is then polled until bit 3 (data request) or bit 0 (error) is 1. If bit 0 is set, the result is 4 (error) and no data is read.
- R7: On data request, exactly 256 reads of offset 0 follow, one per cycle. Each is flagged by `word_valid_o`, with `word_idx_o` going 0 to 255 in order, and the probe ends with result 0 (disk).
- R8: After result 0, `cap28_o` holds {word 61, word 60}, `cap48_o` holds {word 103, word 102, word 101, word 100}, and `lba48_ok_o` holds bit 10 of word 83. A new probe clears all three to zero.
- R9: In each poll phase (busy wait, data-request wait), `tmo_limit_i` consecutive status reads without the awaited condition end the probe with result 5 (timeout). The limit must be at least 1.
- R10: `done_o` is high for exactly one cycle per probe, and `result_o` holds its value until the next probe ends. After reset, all strobes and `done_o` are low.
- R11: `bus_rd_o` and `bus_wr_o` are never high together. `bus_alt_o` stays low, so all status reads use the regular status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, taken while idle |
| unit_sel_i | input | 1 | 0 primary unit, 1 secondary unit |
| tmo_limit_i | input | TMO_W | Failed status reads allowed per poll phase |
| bus_addr_o | output | 3 | Task-file register offset |
| bus_alt_o | output | 1 | Control/alternate-status select |
| bus_rd_o | output | 1 | Read strobe; data sampled the same cycle |
| bus_wr_o | output | 1 | Write strobe |
| bus_wdata_o | output | 16 | Write data |
| bus_rdata_i | input | 16 | Read data |
| word_valid_o | output | 1 | Identification word present |
| word_idx_o | output | IDX_W | Index of the present word |
| word_data_o | output | 16 | Identification word |
| done_o | output | 1 | One-cycle end-of-probe pulse |
| result_o | output | 3 | 0 disk, 1 floating, 2 no device, 3 non-disk, 4 error, 5 timeout |
| sig_mid_o | output | 8 | Byte read from offset 4 |
| sig_hi_o | output | 8 | Byte read from offset 5 |
| cap28_o | output | 32 | 28-bit addressable sector count |
| cap48_o | output | 64 | 48-bit addressable sector count |
| lba48_ok_o | output | 1 | 48-bit addressing supported |

## Verification
The hardest cases to reach are the edges of the two poll timeouts. One is a device that meets its condition on exactly the last allowed read, and the other a device that misses by one. The difficulty is that the busy phase starts one read after the command check. The bench's drive model counts the status reads after the command. It is given a busy-read count and a data-request delay, and both are swept across the timeout limit, with and without the error flag. The busy status carries a stray error bit, so a sequencer that looks at other bits during busy is exposed.

// File: rtl/ata_probe_pkg.sv
package ata_probe_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_FLOAT, ST_SEL, ST_CLR, ST_CMD, ST_CHK,
    ST_BSY, ST_SIGM, ST_SIGH, ST_DRQ, ST_DATA
  } probe_state_e;

  localparam logic [2:0] RES_DISK    = 3'd0;
  localparam logic [2:0] RES_FLOAT   = 3'd1;
  localparam logic [2:0] RES_NODEV   = 3'd2;
  localparam logic [2:0] RES_NONDISK = 3'd3;
  localparam logic [2:0] RES_ERROR   = 3'd4;
  localparam logic [2:0] RES_TIMEOUT = 3'd5;

  localparam logic [2:0] OFS_DATA = 3'd0;
  localparam logic [2:0] OFS_CNT  = 3'd2;
  localparam logic [2:0] OFS_MID  = 3'd4;
  localparam logic [2:0] OFS_HI   = 3'd5;
  localparam logic [2:0] OFS_DEV  = 3'd6;
  localparam logic [2:0] OFS_STAT = 3'd7;

  localparam logic [7:0] CMD_IDENT  = 8'hEC;
  localparam logic [7:0] DEV_BASE   = 8'hA0;
  localparam int         BIT_BUSY   = 7;
  localparam int         BIT_DREQ   = 3;
  localparam int         BIT_FAULT  = 0;

  localparam int WRD_CAP28 = 60;
  localparam int WRD_FEAT  = 83;
  localparam int BIT_L48   = 10;
  localparam int WRD_CAP48 = 100;
endpackage

// File: rtl/ata_probe_timer.sv
module ata_probe_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             miss_i,
  input  logic [TMO_W-1:0] limit_i,
  output logic             expire_o
);
  logic [TMO_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en   = clr_i | miss_i;
  assign cnt_d    = clr_i ? '0 : cnt_q + 1'b1;
  assign expire_o = miss_i && (cnt_q == limit_i - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ata_probe_capture.sv
module ata_probe_capture
  import ata_probe_pkg::*;
#(
  parameter int WORDS = 256,
  parameter int IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             wvalid_i,
  input  logic [15:0]      wdata_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             last_o,
  output logic [31:0]      cap28_o,
  output logic [63:0]      cap48_o,
  output logic             l48_o
);
  localparam int CAP48_WORDS = 4;

  logic [IDX_W-1:0] idx_q;
  logic [31:0]      c28_q;
  logic [63:0]      c48_q;
  logic             l48_q;

  assign idx_o   = idx_q;
  assign last_o  = (idx_q == IDX_W'(WORDS - 1));
  assign cap28_o = c28_q;
  assign cap48_o = c48_q;
  assign l48_o   = l48_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      c28_q <= '0;
      c48_q <= '0;
      l48_q <= 1'b0;
    end else if (clr_i) begin
      idx_q <= '0;
      c28_q <= '0;
      c48_q <= '0;
      l48_q <= 1'b0;
    end else if (wvalid_i) begin
      idx_q <= idx_q + 1'b1;
      if (idx_q == IDX_W'(WRD_CAP28))     c28_q[15:0]  <= wdata_i;
      if (idx_q == IDX_W'(WRD_CAP28 + 1)) c28_q[31:16] <= wdata_i;
      if (idx_q == IDX_W'(WRD_FEAT))      l48_q        <= wdata_i[BIT_L48];
      for (int k = 0; k < CAP48_WORDS; k++)
        if (idx_q == IDX_W'(WRD_CAP48 + k)) c48_q[16*k +: 16] <= wdata_i;
    end
  end
endmodule

// File: rtl/ata_probe_fsm.sv
module ata_probe_fsm
  import ata_probe_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        unit_i,
  input  logic [15:0] rdata_i,
  input  logic        expire_i,
  input  logic        last_i,
  output logic [2:0]  addr_o,
  output logic        rd_o,
  output logic        wr_o,
  output logic [15:0] wdata_o,
  output logic        tmr_clr_o,
  output logic        tmr_miss_o,
  output logic        cap_clr_o,
  output logic        wvalid_o,
  output logic        done_o,
  output logic [2:0]  result_o,
  output logic [7:0]  sig_mid_o,
  output logic [7:0]  sig_hi_o
);
  probe_state_e state_q, state_d;
  logic [1:0]   clr_q;
  logic         unit_q;
  logic         done_q;
  logic [2:0]   res_q;
  logic [7:0]   mid_q, hi_q;

  logic         fin;
  logic [2:0]   fin_res;
  logic         mid_ld, hi_ld;
  logic [7:0]   rbyte;

  assign rbyte     = rdata_i[7:0];
  assign done_o    = done_q;
  assign result_o  = res_q;
  assign sig_mid_o = mid_q;
  assign sig_hi_o  = hi_q;

  always_comb begin
    state_d    = state_q;
    addr_o     = OFS_STAT;
    rd_o       = 1'b0;
    wr_o       = 1'b0;
    wdata_o    = '0;
    tmr_clr_o  = 1'b0;
    tmr_miss_o = 1'b0;
    cap_clr_o  = 1'b0;
    wvalid_o   = 1'b0;
    fin        = 1'b0;
    fin_res    = RES_DISK;
    mid_ld     = 1'b0;
    hi_ld      = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        cap_clr_o = 1'b1;
        state_d   = ST_FLOAT;
      end
      ST_FLOAT: begin
        rd_o = 1'b1;
        if (rbyte == 8'hFF) begin
          fin = 1'b1; fin_res = RES_FLOAT; state_d = ST_IDLE;
        end else state_d = ST_SEL;
      end
      ST_SEL: begin
        wr_o    = 1'b1;
        addr_o  = OFS_DEV;
        wdata_o = {8'h00, DEV_BASE | {3'b000, unit_q, 4'b0000}};
        state_d = ST_CLR;
      end
      ST_CLR: begin
        wr_o   = 1'b1;
        addr_o = OFS_CNT + {1'b0, clr_q};
        if (clr_q == 2'd3) state_d = ST_CMD;
      end
      ST_CMD: begin
        wr_o      = 1'b1;
        wdata_o   = {8'h00, CMD_IDENT};
        tmr_clr_o = 1'b1;
        state_d   = ST_CHK;
      end
      ST_CHK: begin
        rd_o = 1'b1;
        if (rbyte == 8'h00) begin
          fin = 1'b1; fin_res = RES_NODEV; state_d = ST_IDLE;
        end else state_d = ST_BSY;
      end
      ST_BSY: begin
        rd_o = 1'b1;
        if (!rbyte[BIT_BUSY]) begin
          tmr_clr_o = 1'b1;
          state_d   = ST_SIGM;
        end else begin
          tmr_miss_o = 1'b1;
          if (expire_i) begin
            fin = 1'b1; fin_res = RES_TIMEOUT; state_d = ST_IDLE;
          end
        end
      end
      ST_SIGM: begin
        rd_o = 1'b1; addr_o = OFS_MID; mid_ld = 1'b1; state_d = ST_SIGH;
      end
      ST_SIGH: begin
        rd_o = 1'b1; addr_o = OFS_HI; hi_ld = 1'b1;
        if ((mid_q != 8'h00) || (rbyte != 8'h00)) begin
          fin = 1'b1; fin_res = RES_NONDISK; state_d = ST_IDLE;
        end else state_d = ST_DRQ;
      end
      ST_DRQ: begin
        rd_o = 1'b1;
        if (!rbyte[BIT_BUSY] && rbyte[BIT_FAULT]) begin
          fin = 1'b1; fin_res = RES_ERROR; state_d = ST_IDLE;
        end else if (!rbyte[BIT_BUSY] && rbyte[BIT_DREQ]) begin
          state_d = ST_DATA;
        end else begin
          tmr_miss_o = 1'b1;
          if (expire_i) begin
            fin = 1'b1; fin_res = RES_TIMEOUT; state_d = ST_IDLE;
          end
        end
      end
      ST_DATA: begin
        rd_o = 1'b1; addr_o = OFS_DATA; wvalid_o = 1'b1;
        if (last_i) begin
          fin = 1'b1; fin_res = RES_DISK; state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      clr_q   <= '0;
      unit_q  <= 1'b0;
      done_q  <= 1'b0;
      res_q   <= RES_DISK;
      mid_q   <= '0;
      hi_q    <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= fin;
      if (fin) res_q <= fin_res;
      if (state_q == ST_CLR) clr_q <= clr_q + 1'b1;
      else                   clr_q <= '0;
      if (cap_clr_o) begin
        unit_q <= unit_i;
        mid_q  <= '0;
        hi_q   <= '0;
      end else begin
        if (mid_ld) mid_q <= rbyte;
        if (hi_ld)  hi_q  <= rbyte;
      end
    end
  end
endmodule

// File: rtl/ata_ident_probe.sv
module ata_ident_probe #(
  parameter int TMO_W = 16,
  parameter int WORDS = 256,
  parameter int IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             unit_sel_i,
  input  logic [TMO_W-1:0] tmo_limit_i,
  output logic [2:0]       bus_addr_o,
  output logic             bus_alt_o,
  output logic             bus_rd_o,
  output logic             bus_wr_o,
  output logic [15:0]      bus_wdata_o,
  input  logic [15:0]      bus_rdata_i,
  output logic             word_valid_o,
  output logic [IDX_W-1:0] word_idx_o,
  output logic [15:0]      word_data_o,
  output logic             done_o,
  output logic [2:0]       result_o,
  output logic [7:0]       sig_mid_o,
  output logic [7:0]       sig_hi_o,
  output logic [31:0]      cap28_o,
  output logic [63:0]      cap48_o,
  output logic             lba48_ok_o
);
  logic tmr_clr, tmr_miss, tmr_exp, cap_clr, wvalid, last;

  assign bus_alt_o    = 1'b0;
  assign word_valid_o = wvalid;
  assign word_data_o  = bus_rdata_i;

  ata_probe_fsm i_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .unit_i     (unit_sel_i),
    .rdata_i    (bus_rdata_i),
    .expire_i   (tmr_exp),
    .last_i     (last),
    .addr_o     (bus_addr_o),
    .rd_o       (bus_rd_o),
    .wr_o       (bus_wr_o),
    .wdata_o    (bus_wdata_o),
    .tmr_clr_o  (tmr_clr),
    .tmr_miss_o (tmr_miss),
    .cap_clr_o  (cap_clr),
    .wvalid_o   (wvalid),
    .done_o     (done_o),
    .result_o   (result_o),
    .sig_mid_o  (sig_mid_o),
    .sig_hi_o   (sig_hi_o)
  );

  ata_probe_timer #(.TMO_W(TMO_W)) i_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (tmr_clr),
    .miss_i   (tmr_miss),
    .limit_i  (tmo_limit_i),
    .expire_o (tmr_exp)
  );

  ata_probe_capture #(.WORDS(WORDS), .IDX_W(IDX_W)) i_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (cap_clr),
    .wvalid_i (wvalid),
    .wdata_i  (bus_rdata_i),
    .idx_o    (word_idx_o),
    .last_o   (last),
    .cap28_o  (cap28_o),
    .cap48_o  (cap48_o),
    .l48_o    (lba48_ok_o)
  );
endmodule

// File: rtl/ata_ident_probe_chk.sv
module ata_ident_probe_chk #(
  parameter int WORDS = 256,
  parameter int IDX_W = $clog2(WORDS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [2:0]       bus_addr_o,
  input logic             bus_alt_o,
  input logic             bus_rd_o,
  input logic             bus_wr_o,
  input logic [15:0]      bus_wdata_o,
  input logic             word_valid_o,
  input logic [IDX_W-1:0] word_idx_o,
  input logic             done_o,
  input logic [2:0]       result_o
);
  logic [7:0]     wr_seen;
  logic [IDX_W:0] words_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_seen    <= '0;
      words_seen <= '0;
    end else if (start_i) begin
      wr_seen    <= '0;
      words_seen <= '0;
    end else begin
      if (bus_wr_o && wr_seen != 8'hFF) wr_seen <= wr_seen + 1'b1;
      if (word_valid_o) words_seen <= words_seen + 1'b1;
    end
  end

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd_o && bus_wr_o)); // R11
  AST_ALT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_alt_o); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R10
  AST_FLOAT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && result_o == 3'd1) |-> (wr_seen == 8'd0)); // R1
  AST_SELECT_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_o && bus_addr_o == 3'd6) |-> (bus_wdata_o == 16'h00A0 || bus_wdata_o == 16'h00B0)); // R2
  AST_INDEX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid_o && $past(word_valid_o)) |-> (word_idx_o == $past(word_idx_o) + 1'b1)); // R7
  AST_FULL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && result_o == 3'd0) |-> (words_seen == (IDX_W+1)'(WORDS))); // R7
endmodule

bind ata_ident_probe ata_ident_probe_chk #(.WORDS(WORDS), .IDX_W(IDX_W)) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .bus_addr_o   (bus_addr_o),
  .bus_alt_o    (bus_alt_o),
  .bus_rd_o     (bus_rd_o),
  .bus_wr_o     (bus_wr_o),
  .bus_wdata_o  (bus_wdata_o),
  .word_valid_o (word_valid_o),
  .word_idx_o   (word_idx_o),
  .done_o       (done_o),
  .result_o     (result_o)
);

// File: tb/test_ata_ident_probe.sv
module test_ata_ident_probe;
  localparam int TMO_W = 16;
  localparam int IDX_W = 8;
  localparam int LIM   = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic             unit_sel_i = 1'b0;
  logic [TMO_W-1:0] tmo_limit_i = TMO_W'(LIM);
  logic [2:0]       bus_addr_o;
  logic             bus_alt_o, bus_rd_o, bus_wr_o;
  logic [15:0]      bus_wdata_o, bus_rdata_i;
  logic             word_valid_o;
  logic [IDX_W-1:0] word_idx_o;
  logic [15:0]      word_data_o;
  logic             done_o;
  logic [2:0]       result_o;
  logic [7:0]       sig_mid_o, sig_hi_o;
  logic [31:0]      cap28_o;
  logic [63:0]      cap48_o;
  logic             lba48_ok_o;

  always #5 clk = ~clk;

  ata_ident_probe i_ata_ident_probe (.*);

  // drive model configuration
  logic       m_float = 0, m_nodev = 0, m_err = 0, m_clr = 0;
  int         m_bsy = 0, m_drq = 0;
  logic [7:0] m_mid = 0, m_hi = 0, m_seed = 0;
  logic       m_cmd;
  int         m_s, m_w;

  function automatic logic [15:0] wfun(int i, logic [7:0] seed);
    return {8'(i) ^ seed, ~8'(i)};
  endfunction

  function automatic logic [7:0] dstat(int s);
    if (m_nodev) return 8'h00;
    if (s < m_bsy) return 8'h81;
    if (s < m_bsy + m_drq) return 8'h50;
    return m_err ? 8'h51 : 8'h58;
  endfunction

  always_comb begin
    bus_rdata_i = 16'h0000;
    case (bus_addr_o)
      3'd0: bus_rdata_i = wfun(m_w, m_seed);
      3'd4: bus_rdata_i = {8'h00, m_cmd ? m_mid : 8'h00};
      3'd5: bus_rdata_i = {8'h00, m_cmd ? m_hi : 8'h00};
      3'd7: bus_rdata_i = {8'h00, m_cmd ? dstat(m_s) : (m_float ? 8'hFF : 8'h50)};
      default: bus_rdata_i = 16'h0000;
    endcase
  end

  always @(posedge clk) begin
    if (m_clr) begin
      m_cmd <= 1'b0; m_s <= 0; m_w <= 0;
    end else begin
      if (bus_wr_o && bus_addr_o == 3'd7) begin
        m_cmd <= 1'b1; m_s <= 0; m_w <= 0;
      end
      if (bus_rd_o && bus_addr_o == 3'd7 && m_cmd) m_s <= m_s + 1;
      if (bus_rd_o && bus_addr_o == 3'd0) m_w <= m_w + 1;
    end
  end

  // monitors
  int          wr_cnt = 0, wv_cnt = 0, wv_bad = 0, first_acc = 0;
  logic [2:0]  wl_a [0:63];
  logic [15:0] wl_d [0:63];
  int          last_idx = -1;
  always @(negedge clk) begin
    if (bus_wr_o) begin
      wl_a[wr_cnt % 64] <= bus_addr_o;
      wl_d[wr_cnt % 64] <= bus_wdata_o;
      wr_cnt <= wr_cnt + 1;
    end
    if (word_valid_o) begin
      wv_cnt <= wv_cnt + 1;
      if (word_data_o != wfun(int'(word_idx_o), m_seed)) wv_bad <= wv_bad + 1;
      if (word_idx_o != 0 && int'(word_idx_o) != last_idx + 1) wv_bad <= wv_bad + 1;
      last_idx <= int'(word_idx_o);
    end
  end

  int errors = 0, checks = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic probe(input logic unit, output int res, output bit got);
    @(negedge clk);
    m_clr = 1'b1;
    @(negedge clk);
    m_clr = 1'b0;
    unit_sel_i = unit;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    // first access after start: status read, no write (R1)
    chk(bus_rd_o && !bus_wr_o && bus_addr_o == 3'd7, "R1", {61'd0, bus_addr_o}, 64'd7);
    got = 1'b0;
    res = -1;
    for (int c = 0; c < 2000 && !got; c++) begin
      if (done_o) begin
        got = 1'b1;
        res = int'(result_o);
      end else @(negedge clk);
    end
    if (!got) chk(1'b0, "R10 watchdog", 64'd0, 64'd1);
    else begin
      @(negedge clk);
      chk(!done_o && result_o == 3'(res), "R10", {63'd0, done_o}, 64'd0);
    end
  endtask

  task automatic run_case(input logic unit, input int exp_res, input string req);
    int  res, wb, vb, bb;
    bit  got;
    wb = wr_cnt; vb = wv_cnt; bb = wv_bad;
    probe(unit, res, got);
    chk(res == exp_res, req, 64'(res), 64'(exp_res));
    if (exp_res == 1)
      chk(wr_cnt == wb, "R1", 64'(wr_cnt - wb), 64'd0);
    else begin
      bit ok;
      ok = (wr_cnt - wb == 6);
      ok &= wl_a[wb % 64] == 3'd6 && wl_d[wb % 64] == (unit ? 16'h00B0 : 16'h00A0);
      for (int k = 0; k < 4; k++)
        ok &= wl_a[(wb + 1 + k) % 64] == 3'(2 + k) && wl_d[(wb + 1 + k) % 64] == 16'h0000;
      ok &= wl_a[(wb + 5) % 64] == 3'd7 && wl_d[(wb + 5) % 64] == 16'h00EC;
      chk(ok, "R2", 64'(wr_cnt - wb), 64'd6);
    end
    if (exp_res == 0) begin
      logic [31:0] e28;
      logic [63:0] e48;
      chk(wv_cnt - vb == 256 && wv_bad == bb, "R7", 64'(wv_cnt - vb), 64'd256);
      e28 = {wfun(61, m_seed), wfun(60, m_seed)};
      e48 = {wfun(103, m_seed), wfun(102, m_seed), wfun(101, m_seed), wfun(100, m_seed)};
      chk(cap28_o == e28, "R8 cap28", 64'(cap28_o), 64'(e28));
      chk(cap48_o == e48, "R8 cap48", cap48_o, e48);
      chk(lba48_ok_o == wfun(83, m_seed)[10], "R8 flag", 64'(lba48_ok_o), 64'(wfun(83, m_seed)[10]));
    end else begin
      chk(wv_cnt == vb, "R6 no data", 64'(wv_cnt - vb), 64'd0);
      chk(cap28_o == 0 && cap48_o == 0 && !lba48_ok_o, "R8 cleared", cap48_o, 64'd0);
    end
  endtask

  initial begin
    #200000000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!done_o && !bus_rd_o && !bus_wr_o && !word_valid_o, "R10 reset", 64'(done_o), 64'd0);
    chk(cap28_o == 0 && cap48_o == 0 && result_o == 0, "R10 reset", 64'(result_o), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // floating bus
    m_float = 1; run_case(1'b0, 1, "R1 float"); m_float = 0;
    // status zero after command
    m_nodev = 1; run_case(1'b1, 2, "R3 nodev"); m_nodev = 0;
    // packet device signature, also with error set: signature wins
    m_mid = 8'h14; m_hi = 8'hEB; m_bsy = 2; m_err = 1;
    run_case(1'b0, 3, "R5 nondisk");
    chk(sig_mid_o == 8'h14 && sig_hi_o == 8'hEB, "R5 sig", {48'd0, sig_hi_o, sig_mid_o}, 64'hEB14);
    m_mid = 8'h00; m_hi = 8'hC3; m_err = 0;
    run_case(1'b1, 3, "R5 hi only");
    m_mid = 8'h3C; m_hi = 8'h00;
    run_case(1'b0, 3, "R5 mid only");
    m_mid = 0; m_hi = 0;

    // sweep busy length, data-request delay, error flag, unit
    for (int b = 0; b <= 4; b++)
      for (int d = 0; d <= 5; d++)
        for (int e = 0; e <= 1; e++) begin
          int fb, fd, exp;
          m_bsy = b; m_drq = d; m_err = e[0]; m_seed = 8'(b * 16 + d * 4 + e);
          fb = ((b > 1) ? b : 1) - 1;
          fd = b + d - ((b > 1) ? b : 1) - 1;
          if (fd < 0) fd = 0;
          if (fb >= LIM || fd >= LIM) exp = 5;
          else if (e != 0) exp = 4;
          else exp = 0;
          // R4 busy status carries stray error bit; R6 error vs data; R9 timeout edges
          run_case(1'((b + d + e) % 2), exp, exp == 5 ? "R9 timeout" : (exp == 4 ? "R6 error" : "R4 R7 disk"));
        end

    // longer limit turns a former timeout into success
    tmo_limit_i = 16'd6; m_bsy = 5; m_drq = 5; m_err = 0; m_seed = 8'h04;
    run_case(1'b0, 0, "R9 wide limit");
    chk(bus_alt_o == 1'b0, "R11", 64'(bus_alt_o), 64'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule